// File: doc/BRIEF.md
# DRAM Bank Refresh Command Scheduler

This block issues refresh commands for a memory controller that drives a 16-bank DRAM. Other logic, such as interval timers, sends a one-cycle request pulse for each bank that needs a refresh. The scheduler keeps one pending bit per bank and turns the pending banks into refresh commands. It then offers each command on a valid/grant handshake to the controller's command arbiter.

A mode input picks one of two refresh styles.

- **Bank-addressed style:** every command refreshes exactly one bank. That bank is named on a 4-bit bank-address output.
- **Multibank style:** one command refreshes up to four banks together. The banks are given as a per-bank bit mask on the address output, where bit n stands for bank n.

In both styles the lowest-numbered pending banks are served first. A command stays unchanged until it is granted. When a command is granted, the banks it covers are retired in that same cycle, and the next command can load at once.

Top module: `refresh_cmd_sched`

## Requirements
- R1: When the sampled mode is 0 (bank-addressed), a command has `cmd_multi`=0, `cmd_addr`=0, and `cmd_ba` equal to the index of the lowest-numbered pending bank.
- R2: When the sampled mode is 1 (multibank), a command has `cmd_multi`=1 and `cmd_ba`=0. Bit n of `cmd_addr` is 1 exactly when bank n is refreshed by that command.
- R3: A multibank command sets at least one and at most 4 mask bits. These bits are the lowest-numbered pending banks.
- R4: A request pulse on bit n of `req` makes bank n pending. If no command is outstanding, `cmd_valid` rises on the clock edge that samples the pulse.
- R5: While `cmd_valid`=1 and `grant`=0, all four command outputs hold their values on the next cycle.
- R6: A grant clears the pending bits of every bank the command covers. On that same edge, the next command is loaded from the banks still pending, or `cmd_valid` falls if none remain.
- R7: A request for a bank that is already pending is merged with the existing pending bit, so the bank is refreshed only once.
- R8: If a request for a bank arrives in the cycle in which a command covering that bank is granted, the bank stays pending and is refreshed again.
- R9: `mode_multi` is sampled only when a command is loaded. Changing it while a command is outstanding does not alter that command.
- R10: After reset, and whenever `cmd_valid`=0, `cmd_multi`, `cmd_ba` and `cmd_addr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_multi | input | 1 | Refresh style: 0 = bank-addressed, 1 = multibank |
| req | input | 16 | Per-bank refresh request pulses; bit n = bank n |
| grant | input | 1 | Command accepted by the arbiter this cycle |
| cmd_valid | output | 1 | A refresh command is offered |
| cmd_multi | output | 1 | Offered command is multibank (1) or bank-addressed (0) |
| cmd_ba | output | 4 | Bank index for a bank-addressed command, else 0 |
| cmd_addr | output | 16 | Bank mask for a multibank command, else 0 |

## Verification
The properties assume that `grant` is only meaningful while `cmd_valid` is high. A grant with no command offered is dropped, and the properties tolerate it.

They also assume that `req` and `mode_multi` are stable across each clock edge. The bench meets this by driving every input on the falling edge only.

The random phase pulses `grant` freely, including when no command is offered. It changes `mode_multi` while commands are outstanding. It lets requests collide with grants for the same bank. All of this stays inside these assumptions, so the reference model and the properties see the same input sequence.

// File: rtl/refsched_pkg.sv
package refsched_pkg;
   typedef enum logic {
      REF_SINGLE = 1'b0,
      REF_MULTI  = 1'b1
   } ref_kind_e;
endpackage

// File: rtl/refsched_pending.sv
// Per-bank pending refresh vector: requests set, grants clear, and a set wins.
module refsched_pending #(
   parameter int NUM_BANKS = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] set_i,
   input  logic [NUM_BANKS-1:0] clr_i,
   output logic [NUM_BANKS-1:0] pend_q,
   output logic [NUM_BANKS-1:0] pend_nx
);
   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign pend_nx[b] = (pend_q[b] & ~clr_i[b]) | set_i[b];
      always_ff @(posedge clk) begin
         if (!rst_n) pend_q[b] <= 1'b0;
         else        pend_q[b] <= pend_nx[b];
      end
   end
endmodule

// File: rtl/refsched_lowpick.sv
// Peels the lowest set bits off a vector, one stage per selected bank.
module refsched_lowpick #(
   parameter int NUM_BANKS = 16,
   parameter int GROUP     = 4
) (
   input  logic [NUM_BANKS-1:0] vec_i,
   output logic [NUM_BANKS-1:0] first_oh_o,
   output logic [NUM_BANKS-1:0] group_o
);
   logic [NUM_BANKS-1:0] rem  [GROUP+1];
   logic [NUM_BANKS-1:0] low  [GROUP];
   logic [NUM_BANKS-1:0] acc  [GROUP+1];

   assign rem[0] = vec_i;
   assign acc[0] = '0;
   for (genvar k = 0; k < GROUP; k++) begin : g_stage
      assign low[k]   = rem[k] & (~rem[k] + 1'b1);
      assign rem[k+1] = rem[k] & ~low[k];
      assign acc[k+1] = acc[k] | low[k];
   end
   assign first_oh_o = low[0];
   assign group_o    = acc[GROUP];
endmodule

// File: rtl/refsched_oh2idx.sv
// One-hot to binary index; an all-zero input gives index 0.
module refsched_oh2idx #(
   parameter int NUM_BANKS = 16,
   parameter int IDX_W     = 4
) (
   input  logic [NUM_BANKS-1:0] oh_i,
   output logic [IDX_W-1:0]     idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = 0; i < NUM_BANKS; i++)
         if (oh_i[i]) idx_o = idx_o | IDX_W'(i);
   end
endmodule

// File: rtl/refresh_cmd_sched.sv
module refresh_cmd_sched
   import refsched_pkg::*;
#(
   parameter int NUM_BANKS = 16,
   parameter int MAX_GROUP = 4,
   parameter int ADDR_W    = 16,
   localparam int BA_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 mode_multi,
   input  logic [NUM_BANKS-1:0] req,
   input  logic                 grant,
   output logic                 cmd_valid,
   output logic                 cmd_multi,
   output logic [BA_W-1:0]      cmd_ba,
   output logic [ADDR_W-1:0]    cmd_addr
);
   if (ADDR_W < NUM_BANKS) begin : g_bad_addr
      $error("refresh_cmd_sched: ADDR_W must cover one bit per bank");
   end
   if (MAX_GROUP < 1 || MAX_GROUP > NUM_BANKS) begin : g_bad_group
      $error("refresh_cmd_sched: MAX_GROUP out of range");
   end

   logic                 valid_q;
   ref_kind_e            kind_q;
   logic [BA_W-1:0]      ba_q;
   logic [ADDR_W-1:0]    addr_q;

   logic [NUM_BANKS-1:0] covered, clr, pend_q, pend_nx;
   logic [NUM_BANKS-1:0] first_oh, group_mask;
   logic [BA_W-1:0]      first_idx;
   logic                 load, any_pend;

   // Banks retired by the command currently on the outputs.
   always_comb begin
      if (kind_q == REF_MULTI) covered = addr_q[NUM_BANKS-1:0];
      else                     covered = NUM_BANKS'(1) << ba_q;
   end
   assign clr  = (valid_q && grant) ? covered : '0;
   assign load = !valid_q || grant;

   refsched_pending #(.NUM_BANKS(NUM_BANKS)) u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (req),
      .clr_i  (clr),
      .pend_q (pend_q),
      .pend_nx(pend_nx)
   );

   refsched_lowpick #(.NUM_BANKS(NUM_BANKS), .GROUP(MAX_GROUP)) u_pick (
      .vec_i     (pend_nx),
      .first_oh_o(first_oh),
      .group_o   (group_mask)
   );

   refsched_oh2idx #(.NUM_BANKS(NUM_BANKS), .IDX_W(BA_W)) u_idx (
      .oh_i (first_oh),
      .idx_o(first_idx)
   );

   assign any_pend = |pend_nx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         kind_q  <= REF_SINGLE;
         ba_q    <= '0;
         addr_q  <= '0;
      end else if (load) begin
         valid_q <= any_pend;
         if (any_pend && mode_multi) begin
            kind_q <= REF_MULTI;
            ba_q   <= '0;
            addr_q <= ADDR_W'(group_mask);
         end else if (any_pend) begin
            kind_q <= REF_SINGLE;
            ba_q   <= first_idx;
            addr_q <= '0;
         end else begin
            kind_q <= REF_SINGLE;
            ba_q   <= '0;
            addr_q <= '0;
         end
      end
   end

   assign cmd_valid = valid_q;
   assign cmd_multi = (kind_q == REF_MULTI);
   assign cmd_ba    = ba_q;
   assign cmd_addr  = addr_q;
endmodule

// File: rtl/refsched_chk.sv
module refsched_chk #(
   parameter int NUM_BANKS = 16,
   parameter int MAX_GROUP = 4,
   parameter int ADDR_W    = 16,
   parameter int BA_W      = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 grant,
   input logic                 cmd_valid,
   input logic                 cmd_multi,
   input logic [BA_W-1:0]      cmd_ba,
   input logic [ADDR_W-1:0]    cmd_addr
);
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !grant) |=> (cmd_valid && $stable(cmd_multi)
                                 && $stable(cmd_ba) && $stable(cmd_addr)));

   a_r3_mask_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_multi) |-> ($countones(cmd_addr) >= 1
                                    && $countones(cmd_addr) <= MAX_GROUP));

   a_r2_multi_ba_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_multi) |-> (cmd_ba == '0));

   a_r1_single_addr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_multi) |-> (cmd_addr == '0));

   a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> (!cmd_multi && cmd_ba == '0 && cmd_addr == '0));
endmodule

bind refresh_cmd_sched refsched_chk #(
   .NUM_BANKS(NUM_BANKS), .MAX_GROUP(MAX_GROUP), .ADDR_W(ADDR_W), .BA_W(BA_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .grant    (grant),
   .cmd_valid(cmd_valid),
   .cmd_multi(cmd_multi),
   .cmd_ba   (cmd_ba),
   .cmd_addr (cmd_addr)
);

// File: tb/test_refresh_cmd_sched.sv
module test_refresh_cmd_sched;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_multi = 1'b0;
   logic [15:0] req = '0;
   logic        grant = 1'b0;
   logic        cmd_valid, cmd_multi;
   logic [3:0]  cmd_ba;
   logic [15:0] cmd_addr;

   int checks = 0;
   int errors = 0;

   typedef struct packed {
      logic        v;
      logic        m;
      logic [3:0]  ba;
      logic [15:0] addr;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];

   // reference model state
   logic        m_v = 1'b0, m_m = 1'b0;
   logic [3:0]  m_ba = '0;
   logic [15:0] m_addr = '0, m_pend = '0;

   always #5 clk = ~clk;

   refresh_cmd_sched i_refresh_cmd_sched (
      .clk(clk), .rst_n(rst_n), .mode_multi(mode_multi), .req(req),
      .grant(grant), .cmd_valid(cmd_valid), .cmd_multi(cmd_multi),
      .cmd_ba(cmd_ba), .cmd_addr(cmd_addr)
   );

   function automatic logic [15:0] lowest_four(input logic [15:0] v);
      int n = 0;
      lowest_four = '0;
      for (int i = 0; i < 16; i++)
         if (v[i] && n < 4) begin lowest_four[i] = 1'b1; n++; end
   endfunction

   function automatic logic [3:0] lowest_idx(input logic [15:0] v);
      lowest_idx = '0;
      for (int i = 15; i >= 0; i--) if (v[i]) lowest_idx = 4'(i);
   endfunction

   task automatic compare(input exp_t e, input string tag);
      checks++;
      if (cmd_valid !== e.v || cmd_multi !== e.m || cmd_ba !== e.ba || cmd_addr !== e.addr) begin
         errors++;
         $display("FAIL %s: got v=%b m=%b ba=%0d addr=%h, expected v=%b m=%b ba=%0d addr=%h",
                  tag, cmd_valid, cmd_multi, cmd_ba, cmd_addr, e.v, e.m, e.ba, e.addr);
      end
   endtask

   // driver: apply one cycle of stimulus and queue the expected outputs
   task automatic step(input logic [15:0] r, input logic g, input logic md, input string tag);
      logic [15:0] clr, pn;
      exp_t e;
      @(negedge clk);
      req = r; grant = g; mode_multi = md;
      clr = '0;
      if (m_v && g) clr = m_m ? m_addr : (16'h1 << m_ba);
      pn = (m_pend & ~clr) | r;
      if (!m_v || g) begin
         m_v = |pn;
         m_m = (|pn) && md;
         m_ba = ((|pn) && !md) ? lowest_idx(pn) : 4'd0;
         m_addr = ((|pn) && md) ? lowest_four(pn) : 16'h0;
      end
      m_pend = pn;
      e = '{v: m_v, m: m_m, ba: m_ba, addr: m_addr};
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   // monitor: pop and compare after each edge
   initial forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
   end

   initial begin
      #(200000 * 10);
      checks++; errors++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      compare('0, "R10 reset");
      rst_n = 1'b1;
      step(16'h0000, 1'b0, 1'b0, "R10 idle");
      // bank-addressed
      step(16'h0024, 1'b0, 1'b0, "R4 R1 lowest bank");
      step(16'h0000, 1'b0, 1'b1, "R9 mode change held");
      step(16'h0000, 1'b0, 1'b1, "R5 hold");
      step(16'h0000, 1'b1, 1'b0, "R6 next bank");
      step(16'h0000, 1'b1, 1'b0, "R6 drain");
      // duplicate merge
      step(16'h0008, 1'b0, 1'b0, "R7 first");
      step(16'h0008, 1'b0, 1'b0, "R7 dup");
      step(16'h0000, 1'b1, 1'b0, "R7 single refresh");
      // request collides with grant
      step(16'h0010, 1'b0, 1'b0, "R8 first");
      step(16'h0010, 1'b1, 1'b0, "R8 re-pend");
      step(16'h0000, 1'b1, 1'b0, "R8 drain");
      // multibank
      step(16'h00F6, 1'b0, 1'b1, "R2 R3 mask");
      step(16'h0000, 1'b1, 1'b1, "R3 rest");
      step(16'h0000, 1'b1, 1'b1, "R6 drain");
      step(16'hFFFF, 1'b0, 1'b1, "R3 all banks");
      for (int i = 0; i < 4; i++) step(16'h0000, 1'b1, 1'b1, "R3 groups");
      step(16'h0041, 1'b0, 1'b1, "R9 multi");
      step(16'h0000, 1'b0, 1'b0, "R9 mode held");
      step(16'h0000, 1'b1, 1'b0, "R10 drain");
      // random
      for (int i = 0; i < 600; i++) begin
         logic [15:0] r;
         r = '0;
         for (int b = 0; b < 16; b++) if ($urandom_range(0, 11) == 0) r[b] = 1'b1;
         step(r, 1'($urandom_range(0, 1)), (i % 40) < 20 ? 1'($urandom_range(0, 3) != 0)
                                                         : 1'($urandom_range(0, 3) == 0),
              "R6 random");
      end
      @(negedge clk);
      req = '0; grant = 1'b0;
      repeat (2) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule